// File: doc/BRIEF.md
# NAND Bus-to-ECC Nibble Serializer

This block sits between a NAND flash data bus and a BCH encoder or syndrome engine. It accepts bus words from an 8-bit or 16-bit device and turns them into a stream of 4-bit nibbles, most significant nibble of each message first. Each message section is a whole number of nibbles, and that number is taken from a length input when the section begins. Because a section can start and end on any nibble, one bus word can hold nibbles from two sections. Nibbles that one section does not use stay in the block and open the next section.

The consumer receives one nibble per cycle while nibbles are buffered and a section is open or can be opened. Each nibble comes with a valid flag, a flag that marks the first nibble of a section, and a flag that marks its last. The producer side uses a valid/ready handshake. A synchronous clear discards buffered nibbles and ends any open section.

Top module: `nand_nibble_serializer`

## Requirements
- R1: With `wideMode`=0 a word delivers two nibbles: `wordData[7:4]` first, then `wordData[3:0]`. The upper byte is ignored.
- R2: With `wideMode`=1 a word delivers four nibbles in this order: `wordData[7:4]`, `wordData[3:0]`, `wordData[15:12]`, `wordData[11:8]`.
- R3: `nibFirst` is high with the first nibble of each section (nibble S-1) and low with every other nibble.
- R4: `nibLast` is high with the S-th nibble of a section (nibble 0), where S is the length in effect for that section. A section of length 1 raises both flags on one nibble.
- R5: Nibbles of a word left over when a section ends are not dropped. They are delivered, in order, as the first nibbles of the next section.
- R6: `sectLen` is sampled only when a section's first nibble is emitted. Changing it during a section has no effect on that section.
- R7: While no section is open and `sectLen` is 0, no nibble is emitted and buffered nibbles are kept.
- R8: `wordReady` is high only when the buffer is empty, or when it holds one nibble that is emitted in the same cycle. No more than four nibbles are ever pending.
- R9: A cycle with `clear` high discards all buffered nibbles and closes any open section. `wordReady` and `nibValid` are low in that cycle, and `nibValid` is low in the cycle after it.
- R10: After reset `nibValid` is low and `wordReady` is high.
- R11: While nibbles are buffered and a section is open, or `sectLen` is nonzero, one nibble is emitted every cycle. A back-to-back word stream in 16-bit mode gives a nibble in every cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous flush of buffer and section state |
| wideMode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; change only when idle |
| sectLen | input | SECT_W | Section length in nibbles |
| wordData | input | WORD_W | Bus word |
| wordValid | input | 1 | Bus word present |
| wordReady | output | 1 | Bus word accepted this cycle when valid |
| nibData | output | 4 | Nibble out |
| nibValid | output | 1 | Nibble out is valid |
| nibFirst | output | 1 | Nibble is first of its section |
| nibLast | output | 1 | Nibble is last of its section |

## Verification
The bench targets odd section lengths in 8-bit mode. A design that dropped the unused low nibble would lose data and put the next section out of step. Lengths that cut a 16-bit word in the middle catch a design that restarts at a word boundary, and the lane order test catches a design that swaps the two bytes. A length change in the middle of a section would cut the section short in a design that reads the length live. A zero length, a clear issued inside a section and a gap-free wide stream expose designs that leak nibbles, keep stale ones, or insert bubbles when the buffer refills.

// File: rtl/nibser_pkg.sv
package nibser_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic flush;  // drop all buffered nibbles
    logic pop;    // head nibble consumed this cycle
    logic load;   // capture a new bus word
    logic wide;   // captured word carries four nibbles
  } nib_ctrl_t;
endpackage

// File: rtl/nibser_datapath.sv
module nibser_datapath
  import nibser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NIB_W  = 4,
  localparam int DEPTH = WORD_W / NIB_W,
  localparam int BYTES = WORD_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  nib_ctrl_t         ctrl,
  input  logic [WORD_W-1:0] wordData,
  output logic [CNT_W-1:0]  bufCnt,
  output logic [NIB_W-1:0]  headNib
);

  logic [NIB_W-1:0] slots   [DEPTH];
  logic [NIB_W-1:0] loadNib [DEPTH];

  // Lower byte address first; within a byte, high nibble first
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign loadNib[2*b]   = wordData[8*b+7 -: NIB_W];
    assign loadNib[2*b+1] = wordData[8*b+3 -: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.flush) begin
      bufCnt <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (ctrl.load) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= loadNib[i];
      bufCnt <= ctrl.wide ? CNT_W'(DEPTH) : CNT_W'(DEPTH / 2);
    end else if (ctrl.pop) begin
      for (int i = 0; i < DEPTH - 1; i++) slots[i] <= slots[i+1];
      slots[DEPTH-1] <= '0;
      bufCnt <= bufCnt - CNT_W'(1);
    end
  end

  assign headNib = slots[0];

endmodule

// File: rtl/nibser_control.sv
module nibser_control
  import nibser_pkg::*;
#(
  parameter int SECT_W = 10,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              wideMode,
  input  logic [SECT_W-1:0] sectLen,
  input  logic              wordValid,
  input  logic [CNT_W-1:0]  bufCnt,
  output nib_ctrl_t         ctrl,
  output logic              wordReady,
  output logic              nibValid,
  output logic              nibFirst,
  output logic              nibLast
);

  localparam logic [SECT_W-1:0] ONE = SECT_W'(1);

  logic [SECT_W-1:0] remain;
  logic              sectOpen;
  logic              lenOk;
  logic              bufEmpty;
  logic              bufOne;

  assign sectOpen = (remain != '0);
  assign lenOk    = sectOpen || (sectLen != '0);
  assign bufEmpty = (bufCnt == '0);
  assign bufOne   = (bufCnt == CNT_W'(1));

  assign nibValid  = !clear && !bufEmpty && lenOk;
  assign nibFirst  = nibValid && !sectOpen;
  assign nibLast   = nibValid && (sectOpen ? (remain == ONE) : (sectLen == ONE));
  assign wordReady = !clear && (bufEmpty || (bufOne && nibValid));

  always_comb begin
    ctrl.flush = clear;
    ctrl.pop   = nibValid;
    ctrl.load  = wordReady && wordValid;
    ctrl.wide  = wideMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      remain <= '0;
    end else if (nibValid) begin
      remain <= sectOpen ? (remain - ONE) : (sectLen - ONE);
    end
  end

endmodule

// File: rtl/nand_nibble_serializer.sv
module nand_nibble_serializer
  import nibser_pkg::*;
#(
  parameter int SECT_W = 10,
  parameter int WORD_W = 16,
  localparam int NIB_W = 4,
  localparam int CNT_W = $clog2(WORD_W / NIB_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              wideMode,
  input  logic [SECT_W-1:0] sectLen,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordValid,
  output logic              wordReady,
  output logic [NIB_W-1:0]  nibData,
  output logic              nibValid,
  output logic              nibFirst,
  output logic              nibLast
);

  nib_ctrl_t        ctrl;
  logic [CNT_W-1:0] bufCnt;

  nibser_control #(.SECT_W(SECT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .wideMode  (wideMode),
    .sectLen   (sectLen),
    .wordValid (wordValid),
    .bufCnt    (bufCnt),
    .ctrl      (ctrl),
    .wordReady (wordReady),
    .nibValid  (nibValid),
    .nibFirst  (nibFirst),
    .nibLast   (nibLast)
  );

  nibser_datapath #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wordData (wordData),
    .bufCnt   (bufCnt),
    .headNib  (nibData)
  );

endmodule

// File: rtl/nibser_checker.sv
module nibser_checker #(
  parameter int SECT_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              wideMode,
  input logic [SECT_W-1:0] sectLen,
  input logic              wordValid,
  input logic              wordReady,
  input logic              nibValid,
  input logic              nibFirst,
  input logic              nibLast
);

  logic [3:0] pend;
  logic       inSect;

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      pend   <= '0;
      inSect <= 1'b0;
    end else begin
      pend <= pend - {3'd0, nibValid}
            + ((wordValid && wordReady) ? (wideMode ? 4'd4 : 4'd2) : 4'd0);
      if (nibValid && nibLast)       inSect <= 1'b0;
      else if (nibValid && nibFirst) inSect <= 1'b1;
    end
  end

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> (pend == 4'd0 || (pend == 4'd1 && nibValid)));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pend <= 4'd4);
  // R3
  first_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nibValid && !inSect) |-> nibFirst);
  // R3
  first_inside_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nibValid && inSect) |-> !nibFirst);
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nibValid && !inSect) |-> (sectLen != '0));
  // R9
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !nibValid);
  // R11
  no_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend != 4'd0 && inSect && !clear) |-> nibValid);

endmodule

bind nand_nibble_serializer nibser_checker #(.SECT_W(SECT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clear     (clear),
  .wideMode  (wideMode),
  .sectLen   (sectLen),
  .wordValid (wordValid),
  .wordReady (wordReady),
  .nibValid  (nibValid),
  .nibFirst  (nibFirst),
  .nibLast   (nibLast)
);

// File: tb/nand_nibble_serializer_test.sv
module nand_nibble_serializer_test;
  localparam int SECT_W = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clear = 1'b0;
  logic              wideMode = 1'b0;
  logic [SECT_W-1:0] sectLen = '0;
  logic [15:0]       wordData = '0;
  logic              wordValid = 1'b0;
  logic              wordReady;
  logic [3:0]        nibData;
  logic              nibValid, nibFirst, nibLast;

  always #5 clk = ~clk;

  nand_nibble_serializer #(.SECT_W(SECT_W), .WORD_W(16)) uut (
    .clk(clk), .rstN(rstN), .clear(clear), .wideMode(wideMode),
    .sectLen(sectLen), .wordData(wordData), .wordValid(wordValid),
    .wordReady(wordReady), .nibData(nibData), .nibValid(nibValid),
    .nibFirst(nibFirst), .nibLast(nibLast)
  );

  int errors = 0;
  int checks = 0;
  logic [3:0] expQ[$];
  int  secLeft = 0;
  int  latLen = 0;
  int  outCount = 0;
  int  firstCount = 0;
  bit  flushReq = 1'b0;
  bit  monOn = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: present a word, wait for acceptance, push expected nibbles
  task automatic sendWord(input logic [15:0] w);
    bit took;
    wordData  = w;
    wordValid = 1'b1;
    took = 1'b0;
    while (!took) begin
      #4;
      took = wordReady;
      @(negedge clk);
    end
    wordValid = 1'b0;
    expQ.push_back(w[7:4]);
    expQ.push_back(w[3:0]);
    if (wideMode) begin
      expQ.push_back(w[15:12]);
      expQ.push_back(w[11:8]);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && expQ.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: samples 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (flushReq) begin
        secLeft = 0;
        flushReq = 1'b0;
      end
      if (monOn) begin
        chk(!wordReady || expQ.size() == 0 || (expQ.size() == 1 && nibValid),
            "R8 ready", int'(wordReady), 0);
        if (nibValid) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R5 unexpected nibble", int'(nibData), -1);
          end else begin
            logic [3:0] e;
            bit ef, el;
            e = expQ.pop_front();
            chk(nibData == e, wideMode ? "R2 data" : "R1 data", int'(nibData), int'(e));
            ef = (secLeft == 0);
            if (ef) begin
              latLen = int'(sectLen);
              chk(latLen != 0, "R7 emit at zero length", latLen, 1);
              firstCount++;
            end
            chk(nibFirst == ef, "R3 first flag", int'(nibFirst), int'(ef));
            el = ef ? (latLen == 1) : (secLeft == 1);
            chk(nibLast == el, "R4 last flag", int'(nibLast), int'(el));
            secLeft = ef ? latLen - 1 : secLeft - 1;
            outCount++;
          end
        end else if (expQ.size() != 0 && !clear && (secLeft != 0 || sectLen != 0)) begin
          chk(1'b0, "R11 gap", 0, 1);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int oc, fc;
    repeat (3) @(negedge clk);
    #4;
    // R10 reset state
    chk(nibValid == 1'b0, "R10 nibValid", int'(nibValid), 0);
    chk(wordReady == 1'b1, "R10 wordReady", int'(wordReady), 1);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);

    // R1: 8-bit mode, one section of 8 nibbles
    wideMode = 1'b0;
    sectLen = 10'd8;
    fc = firstCount;
    sendWord(16'hFF3C); sendWord(16'h007E); sendWord(16'hAA91); sendWord(16'h550F);
    drain();
    chk(expQ.size() == 0, "R1 all delivered", expQ.size(), 0);
    chk(firstCount - fc == 1, "R4 one section", firstCount - fc, 1);

    // R2: 16-bit mode, byte lanes
    wideMode = 1'b1;
    sectLen = 10'd8;
    sendWord(16'h1234); sendWord(16'hBEEF);
    drain();
    chk(expQ.size() == 0, "R2 all delivered", expQ.size(), 0);

    // R5: 8-bit, odd length 3, leftover nibble opens next section
    wideMode = 1'b0;
    sectLen = 10'd3;
    fc = firstCount;
    sendWord(16'h00A1); sendWord(16'h00B2); sendWord(16'h00C3);
    drain();
    chk(firstCount - fc == 2, "R5 two sections", firstCount - fc, 2);
    chk(secLeft == 0, "R5 section closed", secLeft, 0);

    // R7: zero length holds the nibbles
    sectLen = 10'd0;
    oc = outCount;
    sendWord(16'h00D7);
    repeat (6) @(negedge clk);
    chk(outCount == oc, "R7 no output", outCount - oc, 0);
    chk(expQ.size() == 2, "R7 retained", expQ.size(), 2);
    sectLen = 10'd2;
    drain();
    chk(outCount - oc == 2, "R7 released", outCount - oc, 2);

    // R6: 16-bit, length 5 then changed mid-section to 7
    wideMode = 1'b1;
    sectLen = 10'd5;
    fc = firstCount;
    sendWord(16'h5A69);
    @(negedge clk);
    sectLen = 10'd7;
    sendWord(16'hC3F0); sendWord(16'h8421);
    drain();
    chk(firstCount - fc == 2, "R6 sections", firstCount - fc, 2);
    chk(secLeft == 0, "R6 closed", secLeft, 0);

    // R11: gap-free 16-bit stream, length 16
    sectLen = 10'd16;
    oc = outCount;
    sendWord(16'h0123); sendWord(16'h4567); sendWord(16'h89AB); sendWord(16'hCDEF);
    drain();
    chk(outCount - oc == 16, "R11 stream count", outCount - oc, 16);

    // R9: clear inside a section
    sectLen = 10'd16;
    sendWord(16'h7777);
    @(negedge clk);
    clear = 1'b1;
    expQ.delete();
    flushReq = 1'b1;
    #4;
    chk(nibValid == 1'b0 && wordReady == 1'b0, "R9 clear cycle",
        int'(nibValid) + int'(wordReady), 0);
    @(negedge clk);
    clear = 1'b0;
    #4;
    chk(nibValid == 1'b0, "R9 after clear", int'(nibValid), 0);
    @(negedge clk);
    sectLen = 10'd4;
    fc = firstCount;
    sendWord(16'h9E3D);
    drain();
    chk(firstCount - fc == 1, "R9 new section", firstCount - fc, 1);
    chk(expQ.size() == 0, "R9 delivered", expQ.size(), 0);

    // R4: length 1 gives first and last on one nibble
    wideMode = 1'b0;
    sectLen = 10'd1;
    fc = firstCount;
    sendWord(16'h0042);
    drain();
    chk(firstCount - fc == 2, "R4 unit sections", firstCount - fc, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule